// File: doc/BRIEF.md
# AC'97 Output Frame Assembler

This block builds the outgoing serial frame of an AC'97 link and shifts it out one bit per bit clock. Each frame is 256 bit clocks long: a 16-bit tag slot, then twelve 20-bit slots, every field sent most significant bit first. Slots 1 and 2 always belong to a codec command source, which supplies a register address and a register data word. Data slots 3 to 12 are filled from two logical sample channels, A and B. A per-slot routing word picks the channel for each data slot, or leaves the slot empty.

Samples are pulled over ready/valid handshakes during the tag slot, one handshake per assigned slot, in ascending slot order. The tag slot reports which slots really received data, so a slot whose channel had nothing to offer goes out as zeros and is marked invalid. Each channel has its own sample width of 10, 16, 18 or 20 bits. A sample is taken from the low bits of its data bus and placed left-justified in its slot, with the unused low bits sent as zeros.

Top module: `ac97_out_framer`

## Requirements
- R1: After reset the frame position is 0. Frames repeat every 256 bit clocks, and `fsync` is high for the first 16 bit clocks of each frame (positions 0 to 15) and low for the other 240.
- R2: Tag bit 15, the frame-valid flag, is sent at position 0 and is always 1.
- R3: `cmd_ready` is high only at position 0. If `cmd_valid` is high there, slot 1 carries `cmd_addr`, slot 2 carries `cmd_data`, and tag bits 14 and 13 are 1. Otherwise both slots are zeros and both tag bits are 0.
- R4: `slot_map` holds a 3-bit code per data slot. Slot s (3..12) uses bits [3(s-3)+2 : 3(s-3)]. Code 1 selects channel A, code 2 selects channel B, and every other code leaves the slot unassigned. For example, 0x209 routes slots 3, 4 and 6 to channel A.
- R5: At frame position s-2, each assigned data slot s raises the ready of its channel. A handshake there (ready and valid both high) captures that channel's data for slot s.
- R6: Tag bit 15-s, sent at position s, is 1 exactly when slot s captured data in this frame. A slot that captured nothing, because it is unassigned or its channel was not valid, is sent as 20 zero bits.
- R7: The width select is 0 for 10 bits, 1 for 16, 2 for 18 and 3 for 20. The low w bits of the data bus are sent left-justified in the slot, MSB first, followed by 20-w zeros.
- R8: At most one of `a_ready`, `b_ready` and `cmd_ready` is high in any cycle. No ready is raised outside positions 0 to 10, and none is raised for an unassigned slot.
- R9: Slot s (1..12) occupies positions 16+20(s-1) to 35+20(s-1), with slot bit 19 first. Tag bit 15-k is sent at position k, for k from 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_map | input | 30 | Per-slot channel codes for slots 3 to 12 |
| wsel_a | input | 2 | Sample width select for channel A |
| wsel_b | input | 2 | Sample width select for channel B |
| cmd_valid | input | 1 | Codec command available |
| cmd_addr | input | 20 | Command address word for slot 1 |
| cmd_data | input | 20 | Command data word for slot 2 |
| cmd_ready | output | 1 | Command taken this cycle when valid |
| a_valid | input | 1 | Channel A sample available |
| a_data | input | 20 | Channel A sample, right-justified |
| a_ready | output | 1 | Channel A sample taken this cycle when valid |
| b_valid | input | 1 | Channel B sample available |
| b_data | input | 20 | Channel B sample, right-justified |
| b_ready | output | 1 | Channel B sample taken this cycle when valid |
| fsync | output | 1 | Frame sync, high during the tag slot |
| sdata | output | 1 | Serial frame data |

## Verification
Sample fetching overlaps the emission of the tag slot. In the same cycle that a later data slot makes its handshake, the tag bit of an earlier slot is being shifted out, and the last handshake, for slot 12, happens only two positions before that slot's own tag bit. The bench provokes this by assigning every data slot to one channel or the other, and by toggling the valid inputs cycle by cycle. It then judges each received tag bit against the handshakes it saw at the ports, and each slot word against the width-adjusted sample it offered in that handshake cycle.

// File: rtl/ac97_out_pkg.sv
package ac97_out_pkg;
  localparam int SLOT_W     = 20;
  localparam int TAG_W      = 16;
  localparam int N_SLOT     = 12;
  localparam int N_DATA     = N_SLOT - 2;
  localparam int CODE_W     = 3;
  localparam int MAP_W      = N_DATA * CODE_W;
  localparam int WSEL_W     = 2;
  localparam int FRAME_LEN  = TAG_W + N_SLOT * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_LEN);
  localparam int SLOT_IDX_W = $clog2(N_SLOT + 1);
  localparam int BITPOS_W   = $clog2(SLOT_W);

  typedef enum logic [1:0] {SRC_NONE, SRC_A, SRC_B} src_e;

  // Channel code to source; undefined codes leave the slot empty.
  function automatic src_e decode_code(logic [CODE_W-1:0] code);
    case (code)
      CODE_W'(1): return SRC_A;
      CODE_W'(2): return SRC_B;
      default:    return SRC_NONE;
    endcase
  endfunction

  function automatic int unsigned width_of(logic [WSEL_W-1:0] wsel);
    case (wsel)
      2'd0:    return 10;
      2'd1:    return 16;
      2'd2:    return 18;
      default: return 20;
    endcase
  endfunction

  // Keep the low w bits and move them to the top of the slot.
  function automatic logic [SLOT_W-1:0] justify(logic [SLOT_W-1:0] d, logic [WSEL_W-1:0] wsel);
    int unsigned w;
    logic [SLOT_W-1:0] mask;
    w    = width_of(wsel);
    mask = ~({SLOT_W{1'b1}} << w);
    return (d & mask) << (SLOT_W - w);
  endfunction
endpackage

// File: rtl/ac97_slot_timer.sv
module ac97_slot_timer
  import ac97_out_pkg::*;
(
  input  logic                  bclk,
  input  logic                  rst_n,
  output logic [CNT_W-1:0]      cnt,
  output logic [SLOT_IDX_W-1:0] slot_idx,
  output logic [BITPOS_W-1:0]   bitpos,
  output logic                  frame_start
);
  localparam logic [CNT_W-1:0]      LAST_POS  = CNT_W'(FRAME_LEN - 1);
  localparam logic [SLOT_IDX_W-1:0] LAST_SLOT = SLOT_IDX_W'(N_SLOT);

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      cnt      <= '0;
      slot_idx <= '0;
      bitpos   <= BITPOS_W'(TAG_W - 1);
    end else begin
      cnt <= (cnt == LAST_POS) ? '0 : cnt + 1'b1;
      if (bitpos == '0) begin
        if (slot_idx == LAST_SLOT) begin
          slot_idx <= '0;
          bitpos   <= BITPOS_W'(TAG_W - 1);
        end else begin
          slot_idx <= slot_idx + 1'b1;
          bitpos   <= BITPOS_W'(SLOT_W - 1);
        end
      end else begin
        bitpos <= bitpos - 1'b1;
      end
    end
  end

  assign frame_start = (cnt == '0);
endmodule

// File: rtl/ac97_slot_fetch.sv
module ac97_slot_fetch
  import ac97_out_pkg::*;
(
  input  logic                          bclk,
  input  logic                          rst_n,
  input  logic [CNT_W-1:0]              cnt,
  input  logic [MAP_W-1:0]              slot_map,
  input  logic [WSEL_W-1:0]             wsel_a,
  input  logic [WSEL_W-1:0]             wsel_b,
  input  logic                          cmd_valid,
  input  logic [SLOT_W-1:0]             cmd_addr,
  input  logic [SLOT_W-1:0]             cmd_data,
  output logic                          cmd_ready,
  input  logic                          a_valid,
  input  logic [SLOT_W-1:0]             a_data,
  output logic                          a_ready,
  input  logic                          b_valid,
  input  logic [SLOT_W-1:0]             b_data,
  output logic                          b_ready,
  output logic [N_SLOT-1:0]             slot_vld,
  output logic [N_SLOT-1:0][SLOT_W-1:0] slot_word
);
  logic [N_DATA-1:0] a_req, b_req;
  logic              cmd_vld;
  logic [SLOT_W-1:0] addr_q, data_q;

  // Codec command is fetched at frame position 0.
  assign cmd_ready = (cnt == '0);

  always_ff @(posedge bclk) begin
    if (!rst_n) begin
      cmd_vld <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (cmd_ready) begin
      cmd_vld <= cmd_valid;
      addr_q  <= cmd_valid ? cmd_addr : '0;
      data_q  <= cmd_valid ? cmd_data : '0;
    end
  end

  assign slot_vld[0]  = cmd_vld;
  assign slot_vld[1]  = cmd_vld;
  assign slot_word[0] = addr_q;
  assign slot_word[1] = data_q;

  // Data slot i+3 is fetched at frame position i+1.
  for (genvar i = 0; i < N_DATA; i++) begin : g_slot
    src_e              src;
    logic              here, take;
    logic              dvld;
    logic [SLOT_W-1:0] dword, sample;

    assign src      = decode_code(slot_map[i*CODE_W +: CODE_W]);
    assign here     = (cnt == CNT_W'(i + 1));
    assign a_req[i] = here && (src == SRC_A);
    assign b_req[i] = here && (src == SRC_B);
    assign take     = (a_req[i] && a_valid) || (b_req[i] && b_valid);
    assign sample   = (src == SRC_A) ? justify(a_data, wsel_a) : justify(b_data, wsel_b);

    always_ff @(posedge bclk) begin
      if (!rst_n) begin
        dvld  <= 1'b0;
        dword <= '0;
      end else if (here) begin
        dvld  <= take;
        dword <= take ? sample : '0;
      end
    end

    assign slot_vld[i+2]  = dvld;
    assign slot_word[i+2] = dword;
  end

  assign a_ready = |a_req;
  assign b_ready = |b_req;
endmodule

// File: rtl/ac97_frame_serializer.sv
module ac97_frame_serializer
  import ac97_out_pkg::*;
(
  input  logic [SLOT_IDX_W-1:0]         slot_idx,
  input  logic [BITPOS_W-1:0]           bitpos,
  input  logic [N_SLOT-1:0]             slot_vld,
  input  logic [N_SLOT-1:0][SLOT_W-1:0] slot_word,
  output logic                          sdata
);
  logic [TAG_W-1:0]  tag;
  logic [SLOT_W-1:0] sel;

  always_comb begin
    tag = '0;
    tag[TAG_W-1] = 1'b1;
    for (int s = 0; s < N_SLOT; s++) tag[TAG_W-2-s] = slot_vld[s];
  end

  always_comb begin
    if (slot_idx == '0) sel = {{(SLOT_W-TAG_W){1'b0}}, tag};
    else                sel = slot_word[slot_idx - 1'b1];
  end

  assign sdata = sel[bitpos];
endmodule

// File: rtl/ac97_out_framer.sv
module ac97_out_framer
  import ac97_out_pkg::*;
(
  input  logic              bclk,
  input  logic              rst_n,
  input  logic [MAP_W-1:0]  slot_map,
  input  logic [WSEL_W-1:0] wsel_a,
  input  logic [WSEL_W-1:0] wsel_b,
  input  logic              cmd_valid,
  input  logic [SLOT_W-1:0] cmd_addr,
  input  logic [SLOT_W-1:0] cmd_data,
  output logic              cmd_ready,
  input  logic              a_valid,
  input  logic [SLOT_W-1:0] a_data,
  output logic              a_ready,
  input  logic              b_valid,
  input  logic [SLOT_W-1:0] b_data,
  output logic              b_ready,
  output logic              fsync,
  output logic              sdata
);
  logic [CNT_W-1:0]              cnt;
  logic [SLOT_IDX_W-1:0]         slot_idx;
  logic [BITPOS_W-1:0]           bitpos;
  logic                          frame_start;
  logic [N_SLOT-1:0]             slot_vld;
  logic [N_SLOT-1:0][SLOT_W-1:0] slot_word;

  // Named events for the checker.
  logic in_data_slot, cur_slot_vld;

  ac97_slot_timer u_timer (
    .bclk(bclk), .rst_n(rst_n), .cnt(cnt), .slot_idx(slot_idx),
    .bitpos(bitpos), .frame_start(frame_start)
  );

  ac97_slot_fetch u_fetch (
    .bclk(bclk), .rst_n(rst_n), .cnt(cnt), .slot_map(slot_map),
    .wsel_a(wsel_a), .wsel_b(wsel_b),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
    .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
    .slot_vld(slot_vld), .slot_word(slot_word)
  );

  ac97_frame_serializer u_ser (
    .slot_idx(slot_idx), .bitpos(bitpos), .slot_vld(slot_vld),
    .slot_word(slot_word), .sdata(sdata)
  );

  assign fsync        = (slot_idx == '0);
  assign in_data_slot = (slot_idx != '0);
  assign cur_slot_vld = in_data_slot ? slot_vld[slot_idx - 1'b1] : 1'b0;
endmodule

// File: rtl/ac97_out_framer_chk.sv
module ac97_out_framer_chk
  import ac97_out_pkg::*;
(
  input logic bclk,
  input logic rst_n,
  input logic fsync,
  input logic sdata,
  input logic cmd_ready,
  input logic a_ready,
  input logic b_ready,
  input logic frame_start,
  input logic in_data_slot,
  input logic cur_slot_vld
);
  logic [CNT_W-1:0] low_run;

  always_ff @(posedge bclk) begin
    if (!rst_n || fsync) low_run <= '0;
    else                 low_run <= low_run + 1'b1;
  end

  p_sync_gap_r1: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(fsync) |-> low_run == CNT_W'(FRAME_LEN - TAG_W));

  p_frame_flag_r2: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_start |-> sdata);

  p_cmd_at_start_r3: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(fsync) |-> cmd_ready);

  p_empty_slot_zero_r6: assert property (@(posedge bclk) disable iff (!rst_n)
    (in_data_slot && !cur_slot_vld) |-> !sdata);

  p_one_ready_r8: assert property (@(posedge bclk) disable iff (!rst_n)
    $onehot0({cmd_ready, a_ready, b_ready}));

  p_ready_in_tag_r8: assert property (@(posedge bclk) disable iff (!rst_n)
    (a_ready || b_ready) |-> fsync);
endmodule

bind ac97_out_framer ac97_out_framer_chk u_chk (
  .bclk(bclk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata),
  .cmd_ready(cmd_ready), .a_ready(a_ready), .b_ready(b_ready),
  .frame_start(frame_start), .in_data_slot(in_data_slot), .cur_slot_vld(cur_slot_vld)
);

// File: tb/ac97_out_framer_test.sv
module ac97_out_framer_test;
  localparam int NF = 48;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] slot_map = '0;
  logic [1:0]  wsel_a = '0, wsel_b = '0;
  logic        cmd_valid = 1'b0, a_valid = 1'b0, b_valid = 1'b0;
  logic [19:0] cmd_addr = '0, cmd_data = '0, a_data = '0, b_data = '0;
  logic        cmd_ready, a_ready, b_ready, fsync, sdata;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #10 bclk = ~bclk;

  ac97_out_framer uut (
    .bclk(bclk), .rst_n(rst_n), .slot_map(slot_map), .wsel_a(wsel_a), .wsel_b(wsel_b),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
    .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
    .fsync(fsync), .sdata(sdata)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int code_of(logic [29:0] m, int s);
    return int'((m >> (3 * (s - 3))) & 30'd7);
  endfunction

  function automatic logic [19:0] place(logic [19:0] d, logic [1:0] ws);
    longint w, v;
    w = (ws == 2'd0) ? 10 : (ws == 2'd1) ? 16 : (ws == 2'd2) ? 18 : 20;
    v = (longint'(d) % (64'd1 << w)) * (64'd1 << (20 - w));
    return v[19:0];
  endfunction

  function automatic logic [29:0] map_for(int f);
    logic [29:0] m;
    m = '0;
    for (int s = 3; s <= 12; s++) begin
      int c;
      case (f % 6)
        0: c = code_of(30'h209, s);
        1: c = 1;
        2: c = 2;
        3: c = (s % 2 == 0) ? 1 : 2;
        4: c = 7;
        default: c = (f * 7 + s * 3) % 4;
      endcase
      m = m | (30'(c) << (3 * (s - 3)));
    end
    return m;
  endfunction

  function automatic bit valid_for(int mode, int p);
    case (mode % 4)
      0: return 1'b1;
      1: return 1'b0;
      2: return p[0];
      default: return (p % 3 == 0);
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [19:0] exp_w [1:12];
    bit          exp_v [1:12];
    bit          got   [0:255];
    int          sync_err, r5_err, r8_err;

    repeat (3) @(posedge bclk);
    @(negedge bclk);
    // R1: reset state, frame position 0 with sync high and no sample request
    check(fsync == 1'b1 && a_ready == 1'b0 && b_ready == 1'b0, "R1 reset state",
          {fsync, a_ready, b_ready}, 3'b100);
    rst_n = 1'b1;

    for (int f = 0; f < NF; f++) begin
      slot_map = map_for(f);
      wsel_a   = 2'(f % 4);
      wsel_b   = 2'((f / 4) % 4);
      sync_err = 0; r5_err = 0; r8_err = 0;
      for (int s = 1; s <= 12; s++) begin exp_w[s] = '0; exp_v[s] = 0; end

      for (int p = 0; p < 256; p++) begin
        bit ea, eb, ec;
        cmd_valid = (f % 3 != 2);
        cmd_addr  = 20'(f * 4099 + 74565);
        cmd_data  = 20'(f * 313 + 999);
        a_valid   = valid_for(f / 6, p);
        b_valid   = valid_for(f / 6 + 1, p);
        a_data    = 20'(p * 37 + f * 1021 + 5) ^ 20'hA5A5A;
        b_data    = 20'(p * 91 + f * 577 + 3) ^ 20'h5C3E1;
        #1;
        got[p] = sdata;
        if (fsync != (p < 16)) sync_err++;
        ec = (p == 0);
        ea = (p >= 1 && p <= 10) && code_of(slot_map, p + 2) == 1;
        eb = (p >= 1 && p <= 10) && code_of(slot_map, p + 2) == 2;
        if ((ea && !a_ready) || (eb && !b_ready) || (ec && !cmd_ready)) r5_err++;
        if ((!ea && a_ready) || (!eb && b_ready) || (!ec && cmd_ready)) r8_err++;
        if (ec && cmd_valid) begin
          exp_v[1] = 1; exp_v[2] = 1; exp_w[1] = cmd_addr; exp_w[2] = cmd_data;
        end
        if (ea && a_valid) begin exp_v[p+2] = 1; exp_w[p+2] = place(a_data, wsel_a); end
        if (eb && b_valid) begin exp_v[p+2] = 1; exp_w[p+2] = place(b_data, wsel_b); end
        @(posedge bclk);
        @(negedge bclk);
      end

      begin
        logic [19:0] gw [1:12];
        logic [11:0] gt, et;
        logic [239:0] gall, eall;
        for (int s = 1; s <= 12; s++)
          for (int k = 0; k < 20; k++) gw[s][19-k] = got[16 + 20 * (s - 1) + k];
        for (int s = 1; s <= 12; s++) begin gt[12-s] = got[s]; et[12-s] = exp_v[s]; end
        for (int s = 3; s <= 12; s++) begin
          gall[20*(s-3) +: 20] = gw[s];
          eall[20*(s-3) +: 20] = exp_w[s];
        end
        gall[239:200] = '0; eall[239:200] = '0;
        // R1: sync high for positions 0..15 only, frame of 256
        check(sync_err == 0, "R1 sync pattern", sync_err, 0);
        // R2: frame-valid tag bit at position 0
        check(got[0] == 1'b1, "R2 tag bit 15", got[0], 1);
        // R3: codec slots and their tag bits
        check(gw[1] == exp_w[1] && gw[2] == exp_w[2] && got[1] == exp_v[1] && got[2] == exp_v[2],
              "R3 codec slots", {got[1], got[2], gw[1], gw[2]}, {exp_v[1], exp_v[2], exp_w[1], exp_w[2]});
        // R6: slot tag bits match captured handshakes; zero tail positions 13..15
        check(gt == et && got[13] == 0 && got[14] == 0 && got[15] == 0, "R6 slot tags", gt, et);
        // R4 R7 R9: data slot routing, justification and bit order
        check(gall == eall, "R4 R7 R9 data slots", gall[63:0], eall[63:0]);
        // R5: ready raised for every assigned slot in its fetch cycle
        check(r5_err == 0, "R5 fetch ready", r5_err, 0);
        // R8: no ready where none is due
        check(r8_err == 0, "R8 stray ready", r8_err, 0);
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule